// File: doc/BRIEF.md
# EDO DRAM Access Controller

This block sits between a simple host request port and a 64-bit bank of extended-data-out DRAM devices. The bank is built from eight byte lanes. Each lane has its own column strobe, and all lanes share the row strobe, the write strobe and the output-enable strobe. The host gives a linear word address. The controller places the upper part of that address on the multiplexed address bus when it opens a row, and the lower part when it runs a column cycle. A build-time switch chooses between two row/column splits. Writes use a per-byte mask. Reads always return the whole 64-bit word.

A request is taken on a clock edge where `host_req` and `host_ready` are both high. The first access to a closed row opens it. The controller then waits out the row-to-column delay and runs one column cycle. After that, the row stays open. A later request to the same row runs only a new column cycle, which is a page-mode hit. A request to another row closes the open row, waits out the row precharge time, and then opens the new row. Raising `refresh_hold` closes any open row and stops the controller from opening a new one, so an outside refresh engine can take over the bank. A guard counter closes a row that has been open for too long. All timing limits are whole clock cycles, set as parameters.

Top module: `edo_ctrl`

## Requirements
- R1: With `ROW12`=0, address bits [20:10] go on `dram_ma` while the row strobe falls, and bits [9:0] go on `dram_ma` (zero-extended) while the first column strobe falls. With `ROW12`=1, the split is 12 row bits and 9 column bits.
- R2: Column strobe bit n (active low) gates data bits [8n+7:8n]. In a write, only the lanes whose `host_be` bit is 1 pull their strobe low. Every other lane stays high, so those bytes in the DRAM keep their old value.
- R3: In a read, all eight column strobes go low and `dram_oe_n` is low only while a column strobe is low. `dram_we_n` stays high. `dram_dq_in` is captured into `host_rdata` no earlier than `T_CAC` cycles after the column strobe falls and no earlier than `T_RAC` cycles after the row strobe falls. `host_rvalid` is then high for exactly one cycle.
- R4: In a write, `dram_we_n` falls on the same edge as the column strobes, and `dram_dq_oe` drives `dram_dq_out` only while `dram_we_n` is low. The strobes stay low for at least `T_CASW` cycles.
- R5: The row address stays on `dram_ma` for at least `T_RCD` cycles after the row strobe falls, before any column strobe falls.
- R6: While a row is open, a request to the same row runs a new column cycle without raising the row strobe. The column strobes are high for at least `T_CP` cycles between two column cycles.
- R7: A request to a different row closes the open row. The row strobe then stays high for at least `T_RP` cycles before it falls again.
- R8: While `refresh_hold` is 1, `host_ready` is 0, no row is opened, and an open row is closed.
- R9: The row strobe never stays low for more than `T_RAS_MAX` cycles. An open row left idle is closed before that limit.
- R10: After reset, all strobes are inactive (high), `dram_dq_oe` and `host_rvalid` are 0, and `host_ready` is 1 when `refresh_hold` is 0.
- R11: `host_ready` is 1 only in two cases: the controller is idle with the row closed, or the request hits the open row after the column precharge has finished. It is 0 while a row is opening or a column cycle is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| host_req | input | 1 | Request valid |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | 21 | Linear word address |
| host_wdata | input | 64 | Write data |
| host_be | input | 8 | Byte mask for writes |
| host_ready | output | 1 | Request accepted on this edge if `host_req` is high |
| host_rvalid | output | 1 | One-cycle pulse that marks read data as valid |
| host_rdata | output | 64 | Captured read data |
| refresh_hold | input | 1 | Closes the row and blocks new row openings |
| dram_ma | output | 11 | Multiplexed row/column address |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 8 | Per-lane column strobes, active low |
| dram_we_n | output | 1 | Write strobe, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_dq_out | output | 64 | Write data to the bank |
| dram_dq_oe | output | 1 | Drive enable for `dram_dq_out` |
| dram_dq_in | input | 64 | Read data from the bank |

## Verification
The bench uses a bank model that returns garbage until both access windows have passed since the strobes fell. A controller that samples one cycle early therefore reads a wrong word instead of quietly passing. Masked writes land on top of a known pattern, so a controller that strobes a masked lane corrupts a byte that the read-back shows. Page bursts count row-strobe falls, which catches a design that closes and reopens the row on every hit. Row misses, a refresh hold that arrives while a row is open, and an idle row left past the active-time limit each test whether the controller closes the row, and the measured strobe high times show a precharge that is too short.

// File: rtl/edo_ctrl.sv
module edo_ctrl #(
  parameter int LANES     = 8,
  parameter bit ROW12     = 1'b0,
  parameter int T_RCD     = 3,
  parameter int T_CAC     = 4,
  parameter int T_RAC     = 15,
  parameter int T_CASW    = 4,
  parameter int T_CP      = 3,
  parameter int T_RP      = 10,
  parameter int T_RAS_MAX = 25000,
  localparam int DW       = 8 * LANES,
  localparam int ROW_W    = ROW12 ? 12 : 11,
  localparam int COL_W    = ROW12 ? 9 : 10,
  localparam int ADDR_W   = ROW_W + COL_W,
  localparam int MA_W     = ROW_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_req,
  input  logic              host_we,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DW-1:0]     host_wdata,
  input  logic [LANES-1:0]  host_be,
  output logic              host_ready,
  output logic              host_rvalid,
  output logic [DW-1:0]     host_rdata,
  input  logic              refresh_hold,
  output logic [MA_W-1:0]   dram_ma,
  output logic              dram_ras_n,
  output logic [LANES-1:0]  dram_cas_n,
  output logic              dram_we_n,
  output logic              dram_oe_n,
  output logic [DW-1:0]     dram_dq_out,
  output logic              dram_dq_oe,
  input  logic [DW-1:0]     dram_dq_in
);
  localparam int CNT_W     = $clog2(T_RP + T_RAC + T_CASW + T_CP + T_RCD + 2);
  localparam int RC_W      = $clog2(T_RAS_MAX + 2);
  localparam int RAS_LIMIT = T_RAS_MAX - (T_RAC + T_CASW + T_CP + 2);

  typedef enum logic [2:0] {S_IDLE, S_ROW, S_CAS, S_OPEN, S_PRE} state_t;

  state_t             st;
  logic [CNT_W-1:0]   cnt;
  logic [RC_W-1:0]    ras_cnt;
  logic [ROW_W-1:0]   open_row;
  logic [COL_W-1:0]   p_col;
  logic               p_we;
  logic [DW-1:0]      p_wdata;
  logic [LANES-1:0]   p_be;

  wire [ROW_W-1:0] req_row = host_addr[ADDR_W-1 -: ROW_W];
  wire [COL_W-1:0] req_col = host_addr[COL_W-1:0];
  wire             hit     = (req_row == open_row);
  wire [CNT_W:0]   cnt1    = {1'b0, cnt} + 1'b1;
  wire [RC_W:0]    ras1    = {1'b0, ras_cnt} + 1'b1;
  wire             expired = ras_cnt >= RC_W'(RAS_LIMIT);
  wire             cp_done = cnt1 >= (CNT_W+1)'(T_CP);
  wire             s_open  = (st == S_OPEN);

  assign host_ready = !refresh_hold &&
                      ((st == S_IDLE) || (s_open && !expired && hit && cp_done));

  wire accept   = host_req && host_ready;
  wire close_rw = s_open && (refresh_hold || expired || (host_req && !hit));
  wire col_go   = ((st == S_ROW) && cnt1 >= (CNT_W+1)'(T_RCD)) || (s_open && accept);
  wire col_done = p_we ? (cnt1 >= (CNT_W+1)'(T_CASW))
                       : (cnt1 >= (CNT_W+1)'(T_CAC) && ras1 >= (RC_W+1)'(T_RAC));

  wire [COL_W-1:0] c_col = s_open ? req_col    : p_col;
  wire             c_we  = s_open ? host_we    : p_we;
  wire [DW-1:0]    c_wd  = s_open ? host_wdata : p_wdata;
  wire [LANES-1:0] c_be  = s_open ? host_be    : p_be;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= S_IDLE;
      cnt         <= '0;
      ras_cnt     <= '0;
      open_row    <= '0;
      p_col       <= '0;
      p_we        <= 1'b0;
      p_wdata     <= '0;
      p_be        <= '0;
      host_rvalid <= 1'b0;
      host_rdata  <= '0;
      dram_ma     <= '0;
      dram_ras_n  <= 1'b1;
      dram_cas_n  <= '1;
      dram_we_n   <= 1'b1;
      dram_oe_n   <= 1'b1;
      dram_dq_out <= '0;
      dram_dq_oe  <= 1'b0;
    end else begin
      host_rvalid <= 1'b0;
      if (!(&cnt)) cnt <= cnt + 1'b1;
      if (!dram_ras_n && !(&ras_cnt)) ras_cnt <= ras_cnt + 1'b1;

      if (accept) begin
        p_col   <= req_col;
        p_we    <= host_we;
        p_wdata <= host_wdata;
        p_be    <= host_be;
      end

      if (col_go) begin
        st         <= S_CAS;
        cnt        <= '0;
        dram_ma    <= MA_W'(c_col);
        dram_cas_n <= c_we ? ~c_be : '0;
        dram_we_n  <= !c_we;
        dram_oe_n  <= c_we;
        dram_dq_oe <= c_we;
        if (c_we) dram_dq_out <= c_wd;
      end else begin
        case (st)
          S_IDLE: if (accept) begin
            st         <= S_ROW;
            cnt        <= '0;
            ras_cnt    <= '0;
            dram_ras_n <= 1'b0;
            dram_ma    <= req_row;
            open_row   <= req_row;
          end
          S_ROW: ;
          S_CAS: if (col_done) begin
            st         <= S_OPEN;
            cnt        <= '0;
            dram_cas_n <= '1;
            dram_we_n  <= 1'b1;
            dram_oe_n  <= 1'b1;
            dram_dq_oe <= 1'b0;
            if (!p_we) begin
              host_rvalid <= 1'b1;
              host_rdata  <= dram_dq_in;
            end
          end
          S_OPEN: if (close_rw) begin
            st         <= S_PRE;
            cnt        <= '0;
            dram_ras_n <= 1'b1;
          end
          S_PRE: if (cnt1 >= (CNT_W+1)'(T_RP)) st <= S_IDLE;
          default: st <= S_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/edo_ctrl_chk.sv
module edo_ctrl_chk #(
  parameter int LANES     = 8,
  parameter int T_RCD     = 3,
  parameter int T_CAC     = 4,
  parameter int T_CASW    = 4,
  parameter int T_CP      = 3,
  parameter int T_RP      = 10,
  parameter int T_RAS_MAX = 25000
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ras_n,
  input logic [LANES-1:0] cas_n,
  input logic             we_n,
  input logic             oe_n,
  input logic             dq_oe,
  input logic             ready,
  input logic             rvalid,
  input logic             refresh_hold
);
  logic [31:0] lo_run, hi_run, ras_lo, ras_hi;
  logic        col_seen;
  wire         all_hi = &cas_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_run   <= '0;
      hi_run   <= '0;
      ras_lo   <= '0;
      ras_hi   <= 32'(T_RP);
      col_seen <= 1'b0;
    end else begin
      lo_run   <= all_hi ? '0 : lo_run + 1;
      hi_run   <= (ras_n || !all_hi) ? '0 : hi_run + 1;
      ras_lo   <= ras_n ? '0 : ras_lo + 1;
      ras_hi   <= ras_n ? ras_hi + 1 : '0;
      col_seen <= ras_n ? 1'b0 : (all_hi ? col_seen : 1'b1);
    end
  end

  p_rd_cas_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(all_hi) && $past(we_n) |-> lo_run >= 32'(T_CAC));
  p_wr_cas_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(all_hi) && !$past(we_n) |-> lo_run >= 32'(T_CASW));
  p_row_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(all_hi) && !col_seen |-> hi_run >= 32'(T_RCD));
  p_cas_pre_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(all_hi) && col_seen |-> hi_run >= 32'(T_CP));
  p_ras_pre_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> ras_hi >= 32'(T_RP));
  p_ras_max_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !ras_n |-> ras_lo < 32'(T_RAS_MAX));
  p_oe_in_cas_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_n |-> !all_hi && we_n);
  p_drive_wr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> !we_n && !all_hi);
  p_rvalid_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rvalid |=> !rvalid);
  p_hold_no_open_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> !$past(refresh_hold));
  p_hold_no_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
    refresh_hold |-> !ready);
  p_ready_idle_cas_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> all_hi);
endmodule

bind edo_ctrl edo_ctrl_chk #(
  .LANES(LANES), .T_RCD(T_RCD), .T_CAC(T_CAC), .T_CASW(T_CASW),
  .T_CP(T_CP), .T_RP(T_RP), .T_RAS_MAX(T_RAS_MAX)
) u_chk (
  .clk(clk), .rst_n(rst_n), .ras_n(dram_ras_n), .cas_n(dram_cas_n),
  .we_n(dram_we_n), .oe_n(dram_oe_n), .dq_oe(dram_dq_oe),
  .ready(host_ready), .rvalid(host_rvalid), .refresh_hold(refresh_hold)
);

// File: tb/sim_edo_ctrl.sv
`timescale 1ns/1ps
module sim_edo_ctrl;
  localparam int T_RCD = 3, T_CAC = 4, T_RAC = 15, T_CP = 3, T_RP = 10, T_RAS_MAX = 25000;
  localparam logic [63:0] JUNK = 64'hDEAD_BEEF_DEAD_BEEF;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic        req = 0, we = 0, refresh_hold = 0;
  logic [20:0] addr = '0;
  logic [63:0] wdata = '0;
  logic [7:0]  be = '0;
  logic [63:0] dq_in = JUNK;
  wire         ready, rvalid, ras_n, we_n, oe_n, dq_oe;
  wire [63:0]  rdata, dq_out;
  wire [10:0]  ma;
  wire [7:0]   cas_n;

  edo_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .host_req(req), .host_we(we), .host_addr(addr),
    .host_wdata(wdata), .host_be(be), .host_ready(ready), .host_rvalid(rvalid),
    .host_rdata(rdata), .refresh_hold(refresh_hold), .dram_ma(ma), .dram_ras_n(ras_n),
    .dram_cas_n(cas_n), .dram_we_n(we_n), .dram_oe_n(oe_n), .dram_dq_out(dq_out),
    .dram_dq_oe(dq_oe), .dram_dq_in(dq_in)
  );

  int checks = 0, fails = 0;
  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // bank model and port monitors
  logic [63:0] mem [int];
  logic [10:0] m_row = '0, ma_at_ras = '0;
  logic [9:0]  m_col = '0, ma_at_cas = '0;
  logic [7:0]  cas_pat = '1;
  logic        pr_ras = 1, pr_all = 1, seen_col = 0, seen_ras = 0;
  int ras_age = 0, cas_age = 0, ras_falls = 0;
  int rcd_run = 0, rcd_min = 999, gap_run = 0, gap_min = 999;
  int rp_run = 0, rp_min = 999, lo_run = 0, lo_max = 0, viol = 0;

  always @(posedge clk) if (rst_n) begin
    logic        all_hi;
    int          key;
    logic [63:0] w;
    all_hi = &cas_n;
    ras_age <= ras_n ? 0 : ras_age + 1;
    cas_age <= all_hi ? 0 : cas_age + 1;
    if (pr_ras && !ras_n) begin
      m_row <= ma; ma_at_ras <= ma; ras_falls <= ras_falls + 1;
      if (seen_ras && rp_run < rp_min) rp_min <= rp_run;
      seen_ras <= 1;
    end
    if (pr_all && !all_hi) begin
      m_col <= ma[9:0]; ma_at_cas <= ma[9:0]; cas_pat <= cas_n;
      if (!seen_col) begin if (rcd_run < rcd_min) rcd_min <= rcd_run; end
      else if (gap_run < gap_min) gap_min <= gap_run;
      if (!we_n) begin
        key = int'({m_row, ma[9:0]});
        w = mem.exists(key) ? mem[key] : 64'h0;
        for (int i = 0; i < 8; i++) if (!cas_n[i]) w[8*i +: 8] = dq_out[8*i +: 8];
        mem[key] = w;
      end
    end
    seen_col <= ras_n ? 1'b0 : (all_hi ? seen_col : 1'b1);
    rcd_run  <= (!ras_n && all_hi && !seen_col) ? rcd_run + 1 : 0;
    gap_run  <= (!ras_n && all_hi) ? gap_run + 1 : 0;
    rp_run   <= ras_n ? rp_run + 1 : 0;
    lo_run   <= ras_n ? 0 : lo_run + 1;
    if (!ras_n && lo_run + 1 > lo_max) lo_max <= lo_run + 1;
    if ((!oe_n && all_hi) || (dq_oe && we_n) || (!oe_n && !we_n)) viol <= viol + 1;
    pr_ras <= ras_n; pr_all <= all_hi;
  end

  always @(negedge clk) begin
    int key;
    key = int'({m_row, m_col});
    if (!oe_n && !(&cas_n) && cas_age >= T_CAC - 1 && ras_age >= T_RAC - 1)
      dq_in <= mem.exists(key) ? mem[key] : 64'h0;
    else
      dq_in <= JUNK;
  end

  function automatic logic [20:0] adr(input int row, input int col);
    return {11'(row), 10'(col)};
  endfunction

  task automatic issue(input bit w, input logic [20:0] a, input logic [63:0] d, input logic [7:0] b);
    @(negedge clk);
    req = 1; we = w; addr = a; wdata = d; be = b;
    #1;
    while (!ready) begin @(negedge clk); #1; end
    @(posedge clk); #1;
    req = 0;
  endtask

  task automatic rd(input logic [20:0] a, output logic [63:0] d, output int lat);
    issue(0, a, '0, '0);
    lat = 0;
    do begin @(negedge clk); lat++; end while (!rvalid && lat < 200);
    d = rdata;
  endtask

  task automatic wr(input logic [20:0] a, input logic [63:0] d, input logic [7:0] b);
    issue(1, a, d, b);
    repeat (8) @(negedge clk);
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(ras_n === 1'b1, "R10 ras_n", 64'(ras_n), 1);
    chk(cas_n === 8'hFF, "R10 cas_n", 64'(cas_n), 64'hFF);
    chk(we_n === 1'b1 && oe_n === 1'b1, "R10 we_n/oe_n", 64'({we_n, oe_n}), 3);
    chk(dq_oe === 1'b0 && rvalid === 1'b0, "R10 dq_oe/rvalid", 64'({dq_oe, rvalid}), 0);
    chk(ready === 1'b1, "R10 ready", 64'(ready), 1);
  endtask

  task automatic t_basic;
    logic [63:0] d; int lat;
    wr(adr(5, 17), 64'h0123_4567_89AB_CDEF, 8'hFF);
    chk(ma_at_ras == 11'd5, "R1 row on ma", 64'(ma_at_ras), 5);
    chk(ma_at_cas == 10'd17, "R1 column on ma", 64'(ma_at_cas), 17);
    chk(rcd_min >= T_RCD, "R5 row-to-column cycles", 64'(rcd_min), T_RCD);
    chk(cas_pat == 8'h00, "R4 full write strobes", 64'(cas_pat), 0);
    rd(adr(5, 17), d, lat);
    chk(d == 64'h0123_4567_89AB_CDEF, "R3 page read data", d, 64'h0123_4567_89AB_CDEF);
    chk(lat >= T_CAC, "R3 page read latency", 64'(lat), T_CAC);
    rd(adr(9, 17), d, lat);
    chk(d == 64'h0, "R3 fresh row read data", d, 0);
    chk(lat >= T_RAC, "R3 row-open read latency", 64'(lat), T_RAC);
  endtask

  task automatic t_mask;
    logic [63:0] d, e; int lat;
    wr(adr(20, 3), 64'h1111_1111_1111_1111, 8'hFF);
    wr(adr(20, 3), 64'hAAAA_AAAA_AAAA_AAAA, 8'hA5);
    chk(cas_pat == 8'h5A, "R2 masked lanes stay high", 64'(cas_pat), 64'h5A);
    for (int i = 0; i < 8; i++) e[8*i +: 8] = (8'hA5 >> i) & 1 ? 8'hAA : 8'h11;
    rd(adr(20, 3), d, lat);
    chk(d == e, "R2 masked write merge", d, e);
  endtask

  task automatic t_page;
    logic [63:0] d; int lat, f0;
    wr(adr(33, 0), 64'hC0DE_0000_0000_0001, 8'hFF);
    f0 = ras_falls;
    gap_min = 999;
    wr(adr(33, 1), 64'hC0DE_0000_0000_0002, 8'hFF);
    wr(adr(33, 2), 64'hC0DE_0000_0000_0003, 8'hFF);
    rd(adr(33, 1), d, lat);
    chk(d == 64'hC0DE_0000_0000_0002, "R6 burst read col1", d, 64'hC0DE_0000_0000_0002);
    rd(adr(33, 0), d, lat);
    chk(d == 64'hC0DE_0000_0000_0001, "R6 burst read col0", d, 64'hC0DE_0000_0000_0001);
    chk(ras_falls == f0, "R6 no row reopen in burst", 64'(ras_falls), 64'(f0));
    chk(gap_min >= T_CP, "R6 column precharge", 64'(gap_min), T_CP);
  endtask

  task automatic t_miss;
    logic [63:0] d; int lat, f0;
    f0 = ras_falls;
    rp_min = 999;
    wr(adr(100, 7), 64'hBBBB_0000_0000_0100, 8'hFF);
    wr(adr(200, 7), 64'hCCCC_0000_0000_0200, 8'hFF);
    rd(adr(100, 7), d, lat);
    chk(d == 64'hBBBB_0000_0000_0100, "R7 row B data", d, 64'hBBBB_0000_0000_0100);
    chk(ras_falls == f0 + 3, "R7 row reopened per miss", 64'(ras_falls), 64'(f0 + 3));
    chk(rp_min >= T_RP, "R7 row precharge cycles", 64'(rp_min), T_RP);
  endtask

  task automatic t_refresh;
    logic [63:0] d; int lat, f0;
    wr(adr(300, 4), 64'h5555_AAAA_5555_AAAA, 8'hFF);
    chk(ras_n == 1'b0, "R8 row open before hold", 64'(ras_n), 0);
    @(negedge clk); refresh_hold = 1;
    repeat (2) @(negedge clk);
    chk(ras_n == 1'b1, "R8 hold closes row", 64'(ras_n), 1);
    f0 = ras_falls;
    req = 1; we = 0; addr = adr(300, 4);
    repeat (20) begin @(negedge clk); #1; if (ready) break; end
    chk(ready == 1'b0, "R8 ready low under hold", 64'(ready), 0);
    chk(ras_falls == f0 && ras_n == 1'b1, "R8 no row opened", 64'(ras_falls), 64'(f0));
    refresh_hold = 0;
    #1;
    while (!ready) begin @(negedge clk); #1; end
    @(posedge clk); #1; req = 0;
    lat = 0;
    do begin @(negedge clk); lat++; end while (!rvalid && lat < 200);
    chk(rdata == 64'h5555_AAAA_5555_AAAA, "R8 access after hold", rdata, 64'h5555_AAAA_5555_AAAA);
  endtask

  task automatic t_ready;
    @(negedge clk);
    req = 1; we = 1; addr = adr(400, 1); wdata = 64'h1; be = 8'hFF;
    #1;
    while (!ready) begin @(negedge clk); #1; end
    @(posedge clk); #1; req = 0;
    @(negedge clk);
    chk(ready == 1'b0, "R11 busy while row opens", 64'(ready), 0);
    repeat (12) @(negedge clk);
    addr = adr(401, 1); req = 1; #1;
    chk(ready == 1'b0, "R11 not ready on row miss", 64'(ready), 0);
    @(negedge clk); req = 0;
  endtask

  task automatic t_rasmax;
    logic [63:0] d; int lat;
    rd(adr(500, 9), d, lat);
    chk(ras_n == 1'b0, "R9 row left open", 64'(ras_n), 0);
    repeat (T_RAS_MAX + 50) @(negedge clk);
    chk(ras_n == 1'b1, "R9 idle row closed", 64'(ras_n), 1);
    chk(lo_max <= T_RAS_MAX, "R9 row active limit", 64'(lo_max), T_RAS_MAX);
    chk(viol == 0, "R3 strobe combination faults", 64'(viol), 0);
  endtask

  initial begin
    #(4 * 190000);
    checks++; fails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    t_reset;
    t_basic;
    t_mask;
    t_page;
    t_miss;
    t_refresh;
    t_ready;
    t_rasmax;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule